// File: doc/BRIEF.md
# Vectored Interrupt Latch Controller

This block collects interrupt requests for a small 8-bit CPU and turns them into one vector number plus a request strobe. It has five sources: a non-maskable pin, a group of port A pins, a group of port B pins, a timer event and an A/D end-of-conversion event. Each pin group has its own edge-polarity bit. Any pin in a group that shows the selected edge sets that group's pending latch. The non-maskable pin sets its latch on a falling edge. The timer and A/D requests are level requests, each formed from a peripheral flag and its enable. They stay asserted until software clears the flag.

A small option register holds a global enable and the two polarity bits. While the global enable is clear, pin events still set their latches. They are presented only once the enable is set. The CPU acknowledges entry to a routine by pulsing an acknowledge together with the vector number. For a pin-based vector, that acknowledge clears the latch. The block selects one vector at a time by fixed priority. A wake output asks the CPU to leave stop or wait whenever anything is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Vector numbers on `irq_vec` are 3-bit binary: non-maskable = 0, port A group = 1, port B group = 2, timer = 3, A/D = 4.
- R2: While the global enable is 0, no maskable source raises `irq_req`.
- R3: A port event that arrives while the global enable is 0 stays latched. It raises `irq_req` with its vector in the cycle after the enable is written to 1.
- R4: An acknowledge for vector 0, 1 or 2 clears that source's latch at the acknowledging clock edge. An acknowledge carrying any other vector number leaves the latch set.
- R5: When several requests are enabled, the non-maskable source wins, then the lowest-numbered maskable vector.
- R6: A port A event is the selected edge on any of its pins: falling when the port A polarity bit is 0, rising when it is 1. The opposite edge sets nothing.
- R7: Port B events follow the same rule as R6, using the port B polarity bit.
- R8: The timer request equals timer flag AND timer enable. The A/D request equals conversion-done AND A/D enable. Both are combinational levels, an acknowledge does not clear them, and they vanish when the flag falls.
- R9: `wake` is 1 whenever any latch is set or any peripheral request is active, whatever the global enable. Otherwise it is 0.
- R10: A falling edge on `nmi_pin` sets the non-maskable latch. That latch is presented as vector 0 even while the global enable is 0.
- R11: Every pin passes through a two-flop synchronizer and an edge register. A pin change made between clock edges first shows on `wake` after the third rising edge that follows it.
- R12: On reset, the global enable and both polarity bits are 0 and all latches are clear. A cycle with `opt_we` = 1 loads all three option bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, falling-edge active |
| pa_pins | input | PA_W | Port A interrupt pins |
| pb_pins | input | PB_W | Port B interrupt pins |
| tmr_flag | input | 1 | Timer zero flag |
| tmr_en | input | 1 | Timer interrupt enable |
| adc_done | input | 1 | A/D conversion-done flag |
| adc_en | input | 1 | A/D interrupt enable |
| opt_we | input | 1 | Option register write strobe |
| opt_gen | input | 1 | Global enable value to write |
| opt_pa_rise | input | 1 | Port A polarity to write (1 = rising) |
| opt_pb_rise | input | 1 | Port B polarity to write (1 = rising) |
| cpu_ack | input | 1 | CPU entered a vector routine |
| cpu_ack_vec | input | 3 | Vector number being acknowledged |
| irq_req | output | 1 | Interrupt request strobe |
| irq_vec | output | 3 | Selected vector number |
| wake | output | 1 | Leave stop or wait |

## Verification
The bench builds the block with its default widths: four port A pins, eight port B pins and two synchronizer stages. These widths let it drive a middle pin of each group and confirm that every pin reaches the shared vector. The two-stage setting fixes a three-edge path from a pin to `wake`, so the bench checks both the cycle before the latch sets and the cycle it sets. The bench also stacks several requests under a cleared global enable, then releases them one acknowledge at a time to walk the whole priority order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_VEC = 5;
  localparam int VEC_W   = $clog2(NUM_VEC);

  typedef enum logic [VEC_W-1:0] {
    VEC_NMI = 3'd0,
    VEC_PA  = 3'd1,
    VEC_PB  = 3'd2,
    VEC_TMR = 3'd3,
    VEC_ADC = 3'd4
  } vec_e;

  typedef struct packed {
    logic gen;
    logic pa_rise;
    logic pb_rise;
  } opt_t;
endpackage

// File: rtl/irq_edge_grp.sv
module irq_edge_grp #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         rise_sel,
  output logic         evt
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;
  logic [W-1:0] prev_q, prev_d, synced, hits;

  always_comb begin
    stg_d[0] = pins;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  assign synced = stg_q[STAGES-1];
  assign prev_d = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (rise_sel) hits = synced & ~prev_q;
    else          hits = ~synced & prev_q;
  end
  assign evt = |hits;

  // R6/R7: an event needs a pin whose synchronized level just changed
  p_evt_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (synced != prev_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          grant_vld,
  output logic [VW-1:0] grant_idx
);
  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant_vld = 1'b1;
        grant_idx = VW'(i);
      end
    end
  end

  always_comb begin
    if (grant_vld) begin
      p_grant_pending_r5: assert (pend[grant_idx]);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int PA_W        = 4,
  parameter int PB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic [PA_W-1:0]  pa_pins,
  input  logic [PB_W-1:0]  pb_pins,
  input  logic             tmr_flag,
  input  logic             tmr_en,
  input  logic             adc_done,
  input  logic             adc_en,
  input  logic             opt_we,
  input  logic             opt_gen,
  input  logic             opt_pa_rise,
  input  logic             opt_pb_rise,
  input  logic             cpu_ack,
  input  logic [VEC_W-1:0] cpu_ack_vec,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             wake
);
  localparam int NUM_PIN_SRC = 3;

  opt_t opt_q, opt_d;
  logic [NUM_PIN_SRC-1:0] pin_evt, lat_q, lat_d, ack_hit;
  logic tmr_req, adc_req;
  logic [NUM_VEC-1:0] pend;

  // option register
  always_comb begin
    opt_d = opt_q;
    if (opt_we) opt_d = '{gen: opt_gen, pa_rise: opt_pa_rise, pb_rise: opt_pb_rise};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= '0;
    else        opt_q <= opt_d;
  end

  // edge capture per pin source
  irq_edge_grp #(.W(1), .STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pins(nmi_pin), .rise_sel(1'b0), .evt(pin_evt[VEC_NMI]));
  irq_edge_grp #(.W(PA_W), .STAGES(SYNC_STAGES)) u_pa (
    .clk(clk), .rst_n(rst_n), .pins(pa_pins), .rise_sel(opt_q.pa_rise), .evt(pin_evt[VEC_PA]));
  irq_edge_grp #(.W(PB_W), .STAGES(SYNC_STAGES)) u_pb (
    .clk(clk), .rst_n(rst_n), .pins(pb_pins), .rise_sel(opt_q.pb_rise), .evt(pin_evt[VEC_PB]));

  // pending latches: a new event wins over a same-cycle acknowledge
  for (genvar g = 0; g < NUM_PIN_SRC; g++) begin : g_lat
    assign ack_hit[g] = cpu_ack && (cpu_ack_vec == VEC_W'(g));
    assign lat_d[g]   = pin_evt[g] | (lat_q[g] & ~ack_hit[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  // peripheral level requests
  assign tmr_req = tmr_flag & tmr_en;
  assign adc_req = adc_done & adc_en;

  always_comb begin
    pend           = '0;
    pend[VEC_NMI]  = lat_q[VEC_NMI];
    pend[VEC_PA]   = lat_q[VEC_PA] & opt_q.gen;
    pend[VEC_PB]   = lat_q[VEC_PB] & opt_q.gen;
    pend[VEC_TMR]  = tmr_req & opt_q.gen;
    pend[VEC_ADC]  = adc_req & opt_q.gen;
  end

  irq_arbiter #(.N(NUM_VEC), .VW(VEC_W)) u_arb (
    .pend(pend), .grant_vld(irq_req), .grant_idx(irq_vec));

  assign wake = (|lat_q) | tmr_req | adc_req;

  // R2: masked maskable sources never request
  p_gen_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_q.gen && !lat_q[VEC_NMI]) |-> !irq_req);
  // R3: a port A latch holds until its own acknowledge
  p_pa_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[VEC_PA] && !(cpu_ack && cpu_ack_vec == VEC_PA)) |=> lat_q[VEC_PA]);
  // R4: an acknowledge without a new event clears the port B latch
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_ack_vec == VEC_PB && !pin_evt[VEC_PB]) |=> !lat_q[VEC_PB]);
  // R5 and R10: a pending non-maskable latch always owns the output
  p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q[VEC_NMI] |-> (irq_req && irq_vec == VEC_NMI));
  // R9: any request implies wake
  p_req_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  // R12: the option register changes only on a write
  p_opt_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_we |=> $stable(opt_q));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_pin;
  logic [3:0] pa_pins;
  logic [7:0] pb_pins;
  logic tmr_flag, tmr_en, adc_done, adc_en;
  logic opt_we, opt_gen, opt_pa_rise, opt_pb_rise;
  logic cpu_ack;
  logic [2:0] cpu_ack_vec;
  logic irq_req, wake;
  logic [2:0] irq_vec;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .pa_pins(pa_pins), .pb_pins(pb_pins),
    .tmr_flag(tmr_flag), .tmr_en(tmr_en), .adc_done(adc_done), .adc_en(adc_en),
    .opt_we(opt_we), .opt_gen(opt_gen), .opt_pa_rise(opt_pa_rise), .opt_pb_rise(opt_pb_rise),
    .cpu_ack(cpu_ack), .cpu_ack_vec(cpu_ack_vec),
    .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_opt(input logic g, input logic pr, input logic br);
    opt_we = 1'b1; opt_gen = g; opt_pa_rise = pr; opt_pb_rise = br;
    cyc(1);
    opt_we = 1'b0;
  endtask

  task automatic ack(input logic [2:0] v);
    cpu_ack = 1'b1; cpu_ack_vec = v;
    cyc(1);
    cpu_ack = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12", "irq_req after reset", int'(irq_req), 0);
    chk("R12", "wake after reset", int'(wake), 0);
    chk("R12", "irq_vec after reset", int'(irq_vec), 0);
  endtask

  task automatic t_port_a_masked;
    set_opt(1'b0, 1'b0, 1'b0);
    pa_pins[2] = 1'b0;
    cyc(2);
    chk("R11", "wake two edges after pin fall", int'(wake), 0);
    cyc(1);
    chk("R11", "wake three edges after pin fall", int'(wake), 1);
    chk("R2", "irq_req with gen=0", int'(irq_req), 0);
    cyc(3);
    chk("R2", "irq_req still masked", int'(irq_req), 0);
    set_opt(1'b1, 1'b0, 1'b0);
    chk("R3", "irq_req after gen set", int'(irq_req), 1);
    chk("R1", "port A vector", int'(irq_vec), 1);
    ack(3'd1);
    chk("R4", "irq_req after ack 1", int'(irq_req), 0);
    chk("R9", "wake idle", int'(wake), 0);
    pa_pins[2] = 1'b1;
    cyc(4);
    chk("R6", "rising edge ignored when falling selected", int'(wake), 0);
    set_opt(1'b1, 1'b1, 1'b0);
    pa_pins[0] = 1'b0;
    cyc(4);
    chk("R6", "falling edge ignored when rising selected", int'(wake), 0);
    pa_pins[0] = 1'b1;
    cyc(4);
    chk("R6", "rising edge latched when selected", int'(irq_vec), 1);
    ack(3'd1);
    set_opt(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_port_b_rising;
    set_opt(1'b1, 1'b0, 1'b1);
    pb_pins[5] = 1'b0;
    cyc(4);
    chk("R7", "falling ignored on port B", int'(irq_req), 0);
    pb_pins[5] = 1'b1;
    cyc(4);
    chk("R7", "rising latched on port B", int'(irq_req), 1);
    chk("R1", "port B vector", int'(irq_vec), 2);
    ack(3'd3);
    chk("R4", "other-vector ack keeps port B", int'(irq_req), 1);
    ack(3'd2);
    chk("R4", "port B cleared by its ack", int'(irq_req), 0);
  endtask

  task automatic t_periph;
    tmr_flag = 1'b1; tmr_en = 1'b0;
    #1;
    chk("R8", "timer flag without enable", int'(wake), 0);
    @(negedge clk);
    tmr_en = 1'b1;
    #1;
    chk("R8", "timer request", int'(irq_req), 1);
    chk("R1", "timer vector", int'(irq_vec), 3);
    @(negedge clk);
    ack(3'd3);
    chk("R8", "timer survives ack", int'(irq_vec), 3);
    adc_done = 1'b1; adc_en = 1'b1;
    #1;
    chk("R5", "timer beats A/D", int'(irq_vec), 3);
    @(negedge clk);
    tmr_flag = 1'b0;
    #1;
    chk("R1", "A/D vector", int'(irq_vec), 4);
    @(negedge clk);
    adc_done = 1'b0;
    #1;
    chk("R8", "A/D request gone", int'(irq_req), 0);
    @(negedge clk);
  endtask

  task automatic t_priority;
    set_opt(1'b0, 1'b0, 1'b1);
    pb_pins[0] = 1'b0;
    cyc(4);
    pa_pins[1] = 1'b0;
    pb_pins[0] = 1'b1;
    nmi_pin = 1'b0;
    tmr_flag = 1'b1;
    cyc(4);
    chk("R10", "NMI with gen=0", int'(irq_req), 1);
    chk("R5", "NMI first", int'(irq_vec), 0);
    ack(3'd0);
    chk("R2", "rest masked after NMI ack", int'(irq_req), 0);
    chk("R9", "wake while masked pending", int'(wake), 1);
    set_opt(1'b1, 1'b0, 1'b1);
    chk("R5", "port A next", int'(irq_vec), 1);
    ack(3'd1);
    chk("R5", "port B next", int'(irq_vec), 2);
    ack(3'd2);
    chk("R5", "timer last", int'(irq_vec), 3);
    tmr_flag = 1'b0;
    pa_pins[1] = 1'b1;
    nmi_pin = 1'b1;
    cyc(4);
    chk("R9", "all clear", int'(wake), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    nmi_pin = 1'b1; pa_pins = '1; pb_pins = '1;
    tmr_flag = 1'b0; tmr_en = 1'b0; adc_done = 1'b0; adc_en = 1'b0;
    opt_we = 1'b0; opt_gen = 1'b0; opt_pa_rise = 1'b0; opt_pb_rise = 1'b0;
    cpu_ack = 1'b0; cpu_ack_vec = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_port_a_masked();
    t_port_b_rising();
    t_periph();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule